// File: doc/BRIEF.md
# Single-wire gamepad responder

This block plays the controller side of a one-wire, open-drain link on which a host polls a gamepad. Bits use pulse widths inside a fixed 4 µs cell: a short low phase means 1 and a long low phase means 0. The block listens for a host command, recognises its end by counting bits, then answers with a 64-bit word taken from a parallel input, followed by a stop bit. It only ever pulls the line low or lets it go. The line itself and its pull-up sit outside the block.

It is meant as a synthesizable partner for exercising a host poller. It needs no software setup. Timing is set by a cycles-per-microsecond parameter. The line input passes through a two-stage synchronizer before any decision is made.

Top module: `pad_responder`

## Requirements
- R1: While rst_ni is low, line_pull_o is 0. After reset it stays 0 until a complete command has been received.
- R2: A reply starts only after the command has completed and the synchronized line has then been high for GAP_US µs without a break. If the stop bit is still held low when the command completes, the first reply cycle with line_pull_o = 1 falls exactly GAP_US*CYC_PER_US+2 clock cycles after the cycle in which line_i returns to 1.
- R3: Every reply cell lasts 4*CYC_PER_US cycles. A 1 pulls for CYC_PER_US cycles and then releases. A 0 pulls for 3*CYC_PER_US cycles and then releases. line_pull_o = 1 means the line is pulled low.
- R4: The reply sends reply_i[63] first, down to reply_i[0], then one stop cell of value 1. That is 65 cells in all, after which the line stays released.
- R5: reply_i is captured in the cycle the reply starts. Changes to it during the frame do not alter the frame.
- R6: Each falling edge of the line starts a command bit, and each bit is counted 2 µs after its edge. The 25th count completes the command. A burst of only 24 bits produces no reply.
- R7: If no falling edge follows within 10 µs, a partly received command is discarded and later edges start a fresh count. A 25-bit burst with an 11 µs fall-to-fall pause inside it gets no reply.
- R8: A fall-to-fall spacing of 9 µs inside a command does not break it, and the command still gets a reply.
- R9: Line activity during the wait and during the reply, including the block's own pulses, is not counted as a command. Each command yields exactly one frame, and the block then listens again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sensed level of the shared line (0 = low) |
| reply_i | input | REPLY_BITS | Word returned to the host, most significant bit sent first |
| line_pull_o | output | 1 | 1 = pull the line low, 0 = release it |

## Verification
The line reaches the decision logic three registers late: two synchronizer stages plus the edge-detect register. As a result, the hold counter sees a released line two cycles after line_i rises, and the first pull of a reply is due GAP_US*CYC_PER_US+2 cycles after that rise. The transmitter then changes line_pull_o in the cycle right after each clock edge, with no further delay.

The bench drives stimulus just after a rising edge and samples at the falling edge. A behavioural model, which sees the line through the same three-cycle lag, predicts line_pull_o for every cycle. Separate checks decode the pulse widths into bits, measure the start latency in the stretched-stop case, and confirm silence after commands that are cut short or stall.

// File: rtl/pad_resp_pkg.sv
package pad_resp_pkg;

  // Controller phases
  typedef enum logic [1:0] {
    ST_LISTEN = 2'd0,
    ST_HOLD   = 2'd1,
    ST_TALK   = 2'd2
  } resp_state_e;

  // Cell timing in microseconds
  localparam int CELL_US       = 4;
  localparam int SHORT_LOW_US  = 1;
  localparam int LONG_LOW_US   = 3;
  localparam int SAMPLE_US     = 2;
  localparam int TIMEOUT_US    = 10;

endpackage

// File: rtl/pad_resp_sync.sv
module pad_resp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = line_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], line_i};
    end
  endgenerate

  // Idle line is high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/pad_resp_rx.sv
module pad_resp_rx #(
  parameter int CYC_PER_US = 4,
  parameter int CMD_BITS   = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fall_i,
  output logic done_o
);

  import pad_resp_pkg::*;

  localparam int SMP_CYC = SAMPLE_US * CYC_PER_US;
  localparam int TMO_CYC = TIMEOUT_US * CYC_PER_US;
  localparam int TW      = $clog2(TMO_CYC + 1);
  localparam int BW      = $clog2(CMD_BITS + 1);
  localparam logic [TW-1:0] SMP_LAST  = TW'(SMP_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);
  localparam logic [BW-1:0] BITS_LAST = BW'(CMD_BITS - 1);

  logic          active_q, active_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [BW-1:0] bits_q, bits_d;
  logic          hit, expire;

  assign hit    = active_q && (timer_q == SMP_LAST);
  assign expire = active_q && (timer_q == TMO_LAST);

  always_comb begin
    active_d = active_q;
    timer_d  = timer_q;
    bits_d   = bits_q;
    done_o   = 1'b0;
    if (!en_i) begin
      active_d = 1'b0;
      timer_d  = '0;
      bits_d   = '0;
    end else if (fall_i) begin
      active_d = 1'b1;
      timer_d  = '0;
    end else if (active_q) begin
      timer_d = timer_q + 1'b1;
      if (hit) begin
        if (bits_q == BITS_LAST) begin
          done_o   = 1'b1;
          active_d = 1'b0;
          bits_d   = '0;
        end else begin
          bits_d = bits_q + 1'b1;
        end
      end
      if (expire) begin
        active_d = 1'b0;
        bits_d   = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      timer_q  <= '0;
      bits_q   <= '0;
    end else begin
      active_q <= active_d;
      timer_q  <= timer_d;
      bits_q   <= bits_d;
    end
  end

endmodule

// File: rtl/pad_resp_tx.sv
module pad_resp_tx #(
  parameter int CYC_PER_US = 4,
  parameter int WORD_BITS  = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic                 pull_o,
  output logic                 busy_o,
  output logic                 done_o
);

  import pad_resp_pkg::*;

  localparam int FRAME_BITS = WORD_BITS + 1;
  localparam int BIT_CYC    = CELL_US * CYC_PER_US;
  localparam int TW         = $clog2(BIT_CYC);
  localparam int IW         = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] BIT_LAST  = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] ONE_LOW   = TW'(SHORT_LOW_US * CYC_PER_US);
  localparam logic [TW-1:0] ZERO_LOW  = TW'(LONG_LOW_US * CYC_PER_US);
  localparam logic [IW-1:0] IDX_LAST  = IW'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [TW-1:0]         tmr_q, tmr_d;
  logic                  cell_end, tx_en;
  logic [TW-1:0]         low_len;

  assign cell_end = busy_q && (tmr_q == BIT_LAST);
  assign done_o   = cell_end && (idx_q == IDX_LAST);
  assign low_len  = shift_q[FRAME_BITS-1] ? ONE_LOW : ZERO_LOW;
  assign pull_o   = busy_q && (tmr_q < low_len);
  assign busy_o   = busy_q;
  assign tx_en    = start_i | busy_q;

  always_comb begin
    busy_d  = busy_q;
    shift_d = shift_q;
    idx_d   = idx_q;
    tmr_d   = tmr_q;
    if (start_i) begin
      busy_d  = 1'b1;
      shift_d = {word_i, 1'b1};
      idx_d   = '0;
      tmr_d   = '0;
    end else if (cell_end) begin
      tmr_d   = '0;
      shift_d = {shift_q[FRAME_BITS-2:0], 1'b0};
      idx_d   = idx_q + 1'b1;
      if (idx_q == IDX_LAST) busy_d = 1'b0;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shift_q <= '0;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else if (tx_en) begin
      busy_q  <= busy_d;
      shift_q <= shift_d;
      idx_q   <= idx_d;
      tmr_q   <= tmr_d;
    end
  end

endmodule

// File: rtl/pad_responder.sv
module pad_responder #(
  parameter int CYC_PER_US  = 4,
  parameter int REPLY_BITS  = 64,
  parameter int CMD_BITS    = 25,
  parameter int GAP_US      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_i,
  input  logic [REPLY_BITS-1:0] reply_i,
  output logic                  line_pull_o
);

  import pad_resp_pkg::*;

  localparam int GAP_CYC = GAP_US * CYC_PER_US;
  localparam int HW      = $clog2(GAP_CYC + 1);
  localparam logic [HW-1:0] GAP_LAST = HW'(GAP_CYC - 1);

  resp_state_e   state_q, state_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          line_s, line_fall;
  logic          cmd_done, rx_en;
  logic          tx_start, tx_busy, tx_done;

  pad_resp_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .level_o (line_s),
    .fall_o  (line_fall)
  );

  assign rx_en = (state_q == ST_LISTEN);

  pad_resp_rx #(
    .CYC_PER_US (CYC_PER_US),
    .CMD_BITS   (CMD_BITS)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .fall_i (line_fall),
    .done_o (cmd_done)
  );

  pad_resp_tx #(
    .CYC_PER_US (CYC_PER_US),
    .WORD_BITS  (REPLY_BITS)
  ) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .word_i  (reply_i),
    .pull_o  (line_pull_o),
    .busy_o  (tx_busy),
    .done_o  (tx_done)
  );

  // Sequencing: listen, wait for a quiet high line, talk
  always_comb begin
    state_d  = state_q;
    hcnt_d   = hcnt_q;
    tx_start = 1'b0;
    unique case (state_q)
      ST_LISTEN: begin
        if (cmd_done) begin
          state_d = ST_HOLD;
          hcnt_d  = '0;
        end
      end
      ST_HOLD: begin
        if (!line_s) begin
          hcnt_d = '0;
        end else if (hcnt_q == GAP_LAST) begin
          tx_start = 1'b1;
          state_d  = ST_TALK;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ST_TALK: begin
        if (tx_done) state_d = ST_LISTEN;
      end
      default: state_d = ST_LISTEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LISTEN;
      hcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
    end
  end

endmodule

// File: rtl/pad_responder_chk.sv
module pad_responder_chk #(
  parameter int CYC_PER_US = 4,
  parameter int REPLY_BITS = 64
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      line_pull_o,
  input pad_resp_pkg::resp_state_e state_i,
  input logic                      tx_busy_i,
  input logic                      cmd_done_i
);

  import pad_resp_pkg::*;

  localparam int ONE_CYC   = SHORT_LOW_US * CYC_PER_US;
  localparam int ZERO_CYC  = LONG_LOW_US * CYC_PER_US;
  localparam int FRAME_CYC = (REPLY_BITS + 1) * CELL_US * CYC_PER_US;
  localparam int RW        = $clog2(ZERO_CYC + 2);
  localparam int FW        = $clog2(FRAME_CYC + 2);
  localparam logic [RW-1:0] RUN_SAT   = RW'(ZERO_CYC + 1);
  localparam logic [RW-1:0] RUN_ONE   = RW'(ONE_CYC);
  localparam logic [RW-1:0] RUN_ZERO  = RW'(ZERO_CYC);
  localparam logic [FW-1:0] FRM_SAT   = FW'(FRAME_CYC + 1);
  localparam logic [FW-1:0] FRM_MAX   = FW'(FRAME_CYC);

  logic [RW-1:0] run_q;
  logic [FW-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      frame_q <= '0;
    end else begin
      if (!line_pull_o)        run_q <= '0;
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
      if (!tx_busy_i)           frame_q <= '0;
      else if (frame_q != FRM_SAT) frame_q <= frame_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_idle_in_reset: assert (!line_pull_o)
        else $error("line pulled during reset");
    end
  end

  a_r3_pulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_ZERO)
    else $error("low phase longer than a zero cell");

  a_r3_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_pull_o) |-> (run_q == RUN_ONE || run_q == RUN_ZERO))
    else $error("low phase of illegal length");

  a_r4_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q <= FRM_MAX)
    else $error("reply frame too long");

  a_r9_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD) |-> !line_pull_o)
    else $error("line pulled while waiting to reply");

  a_r9_no_cmd_while_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !cmd_done_i)
    else $error("command completed during reply");

endmodule

bind pad_responder pad_responder_chk #(
  .CYC_PER_US (CYC_PER_US),
  .REPLY_BITS (REPLY_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_pull_o (line_pull_o),
  .state_i     (state_q),
  .tx_busy_i   (tx_busy),
  .cmd_done_i  (cmd_done)
);

// File: tb/pad_responder_test.sv
module pad_responder_test;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int GAP_US     = 4;
  localparam int CMD_BITS   = 25;
  localparam int BIT_CYC    = 4 * CPU;
  localparam int ONE_LOW    = CPU;
  localparam int ZERO_LOW   = 3 * CPU;
  localparam int GAP_CYC    = GAP_US * CPU;
  localparam int SMP_CYC    = 2 * CPU;
  localparam int TMO_CYC    = 10 * CPU;
  localparam int FRAME_CYC  = 65 * BIT_CYC;
  localparam int SETTLE     = GAP_CYC + FRAME_CYC + 400;

  logic        clk;
  logic        rst_ni;
  logic        host_drv;
  logic [63:0] reply_word;
  logic        line_pull;
  wire         line_w = host_drv & ~line_pull;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [23:0] cmd_pat = 24'h4C1A05;

  pad_responder #(
    .CYC_PER_US (CPU),
    .GAP_US     (GAP_US)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .line_i      (line_w),
    .reply_i     (reply_word),
    .line_pull_o (line_pull)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: line seen three cycles late
  bit line_smp = 1'b1;
  bit h0 = 1, h1 = 1, h2 = 1, h3 = 1;
  int mode = 0;
  bit act = 0;
  int t = 0, nb = 0, hr = 0;
  bit q[$];
  bit exp_pull = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      h0 = 1; h1 = 1; h2 = 1; h3 = 1;
      mode = 0; act = 0; t = 0; nb = 0; hr = 0;
      q.delete();
      exp_pull = 0;
    end else begin
      bit ls, fl;
      h3 = h2; h2 = h1; h1 = h0; h0 = line_smp;
      ls = h2;
      fl = h3 && !ls;
      case (mode)
        0: begin
          exp_pull = 0;
          if (fl) begin
            act = 1; t = 0;
          end else if (act) begin
            if (t == SMP_CYC - 1) begin
              if (nb == CMD_BITS - 1) begin
                act = 0; nb = 0; mode = 1; hr = 0;
              end else nb++;
            end
            if (t == TMO_CYC - 1) begin
              act = 0; nb = 0;
            end
            t++;
          end
        end
        1: begin
          exp_pull = 0;
          if (!ls) hr = 0;
          else if (hr == GAP_CYC - 1) begin
            for (int i = 63; i >= -1; i--) begin
              bit b;
              b = (i < 0) ? 1'b1 : reply_word[i];
              for (int c = 0; c < BIT_CYC; c++) q.push_back(c < (b ? ONE_LOW : ZERO_LOW));
            end
            mode = 2;
            exp_pull = q.pop_front();
          end else hr++;
        end
        default: begin
          if (q.size() == 0) begin
            mode = 0; exp_pull = 0; act = 0; nb = 0;
          end else exp_pull = q.pop_front();
        end
      endcase
    end
  end

  // Per-cycle compare, pulse decoder, line sampling
  int run = 0;
  int bad = 0;
  bit got[$];

  always @(negedge clk) begin
    if (rst_ni && !finished)
      check(line_pull === exp_pull, "R2 R3 R4 per-cycle model", line_pull, exp_pull);
    if (line_pull) run++;
    else if (run > 0) begin
      if (run == ONE_LOW) got.push_back(1'b1);
      else if (run == ZERO_LOW) got.push_back(1'b0);
      else bad++;
      run = 0;
    end
    line_smp = line_w;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_cmd(input int nbits, input int pause_after, input int pause_cyc, input int stop_low);
    for (int i = 0; i < nbits; i++) begin
      bit b;
      int lo;
      b  = (i == CMD_BITS - 1) ? 1'b1 : cmd_pat[CMD_BITS - 2 - i];
      lo = b ? ONE_LOW : ZERO_LOW;
      if (i == CMD_BITS - 1 && stop_low > 0) lo = stop_low;
      host_drv = 1'b0;
      wait_cyc(lo);
      host_drv = 1'b1;
      if (i == CMD_BITS - 1 && stop_low > 0) return;
      wait_cyc(BIT_CYC - lo + ((i == pause_after) ? pause_cyc : 0));
    end
  endtask

  task automatic check_frame(input logic [63:0] exp, input string tag);
    logic [63:0] w;
    check(got.size() == 65, {tag, " R4 R9 cell count"}, got.size(), 65);
    check(bad == 0, "R3 pulse widths", bad, 0);
    if (got.size() == 65) begin
      w = '0;
      for (int i = 0; i < 64; i++) w[63 - i] = got[i];
      check(w == exp, {tag, " R4 word MSB first"}, w, exp);
      check(got[64] == 1'b1, "R4 stop cell", got[64], 1);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    host_drv   = 1'b1;
    reply_word = '0;
    rst_ni     = 1'b0;
    repeat (4) @(negedge clk);
    check(line_pull == 1'b0, "R1 released in reset", line_pull, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    wait_cyc(50);
    check(line_pull == 1'b0, "R1 released after reset", line_pull, 0);
    check(got.size() == 0, "R1 no pulses before command", got.size(), 0);

    // Plain command, reply with both end bits set
    reply_word = 64'h8000_0000_0000_0001;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, -1, 0, 0);
    wait_cyc(SETTLE);
    check_frame(64'h8000_0000_0000_0001, "R6");

    // Capture: change word during the frame
    reply_word = 64'hA5C3_0F96_3C5A_E718;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, -1, 0, 0);
    wait (line_pull == 1'b1);
    wait_cyc(100);
    reply_word = ~reply_word;
    wait_cyc(SETTLE);
    check_frame(64'hA5C3_0F96_3C5A_E718, "R5 capture");

    // Stop bit held low: start latency from release
    reply_word = 64'h0123_4567_89AB_CDEF;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, -1, 0, 6 * CPU);
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!line_pull && n < 1000);
      check(n == GAP_CYC + 3, "R2 start latency", n, GAP_CYC + 3);
    end
    wait_cyc(SETTLE);
    check_frame(64'h0123_4567_89AB_CDEF, "R2");

    // Only 24 bits: no reply
    got.delete(); bad = 0;
    send_cmd(CMD_BITS - 1, -1, 0, 0);
    wait_cyc(SETTLE);
    check(got.size() == 0, "R6 short command silent", got.size(), 0);

    // 9 us fall-to-fall inside the command: still answered
    reply_word = 64'hFFFF_0000_F0F0_1234;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, 10, 5 * CPU, 0);
    wait_cyc(SETTLE);
    check_frame(64'hFFFF_0000_F0F0_1234, "R8 9us pause");

    // 11 us fall-to-fall: discarded, no reply
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, 10, 7 * CPU, 0);
    wait_cyc(SETTLE);
    check(got.size() == 0, "R7 11us pause silent", got.size(), 0);

    // Recovery after discard
    reply_word = 64'h0000_0000_0000_0000;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, -1, 0, 0);
    wait_cyc(SETTLE);
    check_frame(64'h0, "R7 recovery");

    // Back-to-back commands give one frame each
    reply_word = 64'hDEAD_BEEF_5555_AAAA;
    got.delete(); bad = 0;
    send_cmd(CMD_BITS, -1, 0, 0);
    wait_cyc(SETTLE);
    send_cmd(CMD_BITS, -1, 0, 0);
    wait_cyc(SETTLE);
    check(got.size() == 130, "R9 one frame per command", got.size(), 130);
    check(line_pull == 1'b0, "R4 released after frame", line_pull, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule